// File: doc/BRIEF.md
# Polar Successive-Cancellation LLR Node Processor

This block is the arithmetic node of a successive-cancellation polar decoder. Each cycle it accepts two log-likelihood ratios in sign-magnitude form, a select bit that picks the check-node rule or the variable-node rule, and the partial-sum bit that the variable-node rule needs. It produces one sign-magnitude LLR. A scheduler elsewhere in the decoder feeds it, stores its results and makes the bit decisions.

Both inputs are first converted to two's complement. Two paths then run in parallel. The first computes b + a and b − a and picks one of them with the partial-sum bit. The second forms the min-sum check-node value: the smaller of the two magnitudes, with a sign equal to the XOR of the input signs. The select bit chooses between the two paths. The chosen value is converted back to sign-magnitude with saturation, and it is registered by default. A parameter can remove the output register for a purely combinational use.

Top module: `sclr_pe`

## Requirements
- R1: With `sel_g` = 0 and both input magnitudes nonzero, the output sign bit (bit LLR_W-1) equals the XOR of the two input sign bits.
- R2: With `sel_g` = 0, the output magnitude (bits LLR_W-2..0) equals the smaller of the two input magnitudes.
- R3: With `sel_g` = 1 and `psum` = 0, the output's signed value equals b + a, unless the magnitude of b + a exceeds the largest magnitude.
- R4: With `sel_g` = 1 and `psum` = 1, the output's signed value equals b − a, unless the magnitude of b − a exceeds the largest magnitude.
- R5: When the magnitude of a sum or difference exceeds 2^(LLR_W-1)−1 (127 at the default width), the output magnitude is 127 and the output sign is the sign of the true result.
- R6: A negative-zero input (sign 1, magnitude 0) behaves exactly like +0 in both rules.
- R7: A zero result always leaves with sign bit 0, so the pattern 0x80 never appears on `llr_out`.
- R8: `llr_out` holds the result for the inputs captured at the previous rising clock edge. Synchronous active-high `rst` clears it to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| llr_a | input | LLR_W | First LLR, sign-magnitude, sign in the MSB |
| llr_b | input | LLR_W | Second LLR, sign-magnitude, sign in the MSB |
| psum | input | 1 | Partial-sum bit: 0 selects b + a, 1 selects b − a |
| sel_g | input | 1 | Rule select: 0 selects the check-node rule, 1 selects the variable-node rule |
| llr_out | output | LLR_W | Result LLR, sign-magnitude |

## Verification
Every result appears on `llr_out` one rising edge after its operands and control bits are presented. The reset clear also takes effect at the first rising edge with `rst` high. The bench changes inputs only on falling edges. It compares `llr_out` on the next falling edge, which is half a period after the single register stage has captured the value. Because each vector gets its own full cycle, every comparison refers to exactly one input combination. The checker uses the same one-edge offset through `$past`.

// File: rtl/sclr_pkg.sv
package sclr_pkg;

  // Rule chosen by the select input
  typedef enum logic {
    OP_CHECK = 1'b0,   // min-sum rule
    OP_VAR   = 1'b1    // add/subtract rule
  } pe_op_e;

  // Direction applied to the a operand in the add/subtract rule
  typedef enum logic {
    PS_ADD = 1'b0,
    PS_SUB = 1'b1
  } ps_dir_e;

endpackage

// File: rtl/sclr_sm2tc.sv
// Sign-magnitude to two's complement; negative zero folds onto zero.
module sclr_sm2tc #(
  parameter int W = 8
) (
  input  logic [W-1:0]        sm_in,
  output logic signed [W-1:0] tc_out
);
  localparam int MW = W - 1;

  logic [MW-1:0] mag;
  logic          neg;

  always_comb begin
    mag = sm_in[MW-1:0];
    neg = sm_in[W-1] && (mag != '0);
    if (neg) tc_out = -$signed({1'b0, mag});
    else     tc_out = $signed({1'b0, mag});
  end
endmodule

// File: rtl/sclr_arith.sv
// Parallel add/subtract path and min-sum path, selected by the rule bit.
module sclr_arith
  import sclr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic signed [W-1:0] a_tc,
  input  logic signed [W-1:0] b_tc,
  input  pe_op_e              op,
  input  ps_dir_e             dir,
  output logic signed [W:0]   res
);
  // One guard bit so the sum and difference cannot wrap
  localparam int XW = W + 1;

  logic signed [XW-1:0] a_x, b_x;
  logic signed [XW-1:0] sum_v, dif_v, g_v;
  logic signed [XW-1:0] a_abs, b_abs, min_v, f_v;
  logic                 a_lt, f_neg;

  always_comb begin
    a_x = {a_tc[W-1], a_tc};
    b_x = {b_tc[W-1], b_tc};

    // Adder and subtractor work side by side
    sum_v = b_x + a_x;
    dif_v = b_x - a_x;
    g_v   = (dir == PS_SUB) ? dif_v : sum_v;

    // Min-sum: magnitude compare and sign parity
    a_abs = a_x[XW-1] ? -a_x : a_x;
    b_abs = b_x[XW-1] ? -b_x : b_x;
    a_lt  = (a_abs < b_abs);
    min_v = a_lt ? a_abs : b_abs;
    f_neg = a_x[XW-1] ^ b_x[XW-1];
    f_v   = f_neg ? -min_v : min_v;

    res = (op == OP_VAR) ? g_v : f_v;
  end
endmodule

// File: rtl/sclr_tc2sm.sv
// Two's complement (with guard bit) back to sign-magnitude, saturating.
module sclr_tc2sm #(
  parameter int W = 8
) (
  input  logic signed [W:0] tc_in,
  output logic [W-1:0]      sm_out
);
  localparam int MW = W - 1;
  localparam logic [W:0] MAXM = {2'b00, {MW{1'b1}}};

  logic          neg;
  logic [W:0]    mag_full;
  logic [MW-1:0] mag;

  always_comb begin
    neg      = tc_in[W];
    mag_full = neg ? $unsigned(-tc_in) : $unsigned(tc_in);
    mag      = (mag_full > MAXM) ? MAXM[MW-1:0] : mag_full[MW-1:0];
    // Zero always leaves as +0
    sm_out   = {neg && (mag != '0), mag};
  end
endmodule

// File: rtl/sclr_pe.sv
module sclr_pe
  import sclr_pkg::*;
#(
  parameter int LLR_W   = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LLR_W-1:0] llr_a,
  input  logic [LLR_W-1:0] llr_b,
  input  logic             psum,
  input  logic             sel_g,
  output logic [LLR_W-1:0] llr_out
);
  logic signed [LLR_W-1:0] a_tc, b_tc;
  logic signed [LLR_W:0]   res_tc;
  logic [LLR_W-1:0]        res_sm;
  pe_op_e                  op;
  ps_dir_e                 dir;

  assign op  = pe_op_e'(sel_g);
  assign dir = ps_dir_e'(psum);

  sclr_sm2tc #(.W(LLR_W)) u_cvt_a (.sm_in(llr_a), .tc_out(a_tc));
  sclr_sm2tc #(.W(LLR_W)) u_cvt_b (.sm_in(llr_b), .tc_out(b_tc));

  sclr_arith #(.W(LLR_W)) u_arith (
    .a_tc(a_tc), .b_tc(b_tc), .op(op), .dir(dir), .res(res_tc)
  );

  sclr_tc2sm #(.W(LLR_W)) u_cvt_out (.tc_in(res_tc), .sm_out(res_sm));

  generate
    if (OUT_REG) begin : g_reg
      logic [LLR_W-1:0] out_q;
      always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= res_sm;
      end
      assign llr_out = out_q;
    end else begin : g_comb
      assign llr_out = res_sm;
    end
  endgenerate
endmodule

// File: rtl/sclr_pe_chk.sv
module sclr_pe_chk #(
  parameter int LLR_W   = 8,
  parameter bit OUT_REG = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic [LLR_W-1:0] llr_a,
  input logic [LLR_W-1:0] llr_b,
  input logic             psum,
  input logic             sel_g,
  input logic [LLR_W-1:0] llr_out
);
  localparam int MW   = LLR_W - 1;
  localparam int MAXM = (1 << MW) - 1;

  function automatic int to_int(input logic [LLR_W-1:0] v);
    int m;
    m = int'(v[MW-1:0]);
    return v[LLR_W-1] ? -m : m;
  endfunction

  function automatic int clip(input int v);
    if (v > MAXM)  return MAXM;
    if (v < -MAXM) return -MAXM;
    return v;
  endfunction

  function automatic int lesser(input int x, input int y);
    return (x < y) ? x : y;
  endfunction

  generate
    if (OUT_REG) begin : g_chk
      logic armed, rst_q;
      always_ff @(posedge clk) begin
        rst_q <= rst;
        armed <= !rst;
      end

      // R1
      f_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && !$past(sel_g) && ($past(llr_a[MW-1:0]) != 0) && ($past(llr_b[MW-1:0]) != 0))
        |-> (llr_out[LLR_W-1] == ($past(llr_a[LLR_W-1]) ^ $past(llr_b[LLR_W-1]))));

      // R2
      f_mag_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && !$past(sel_g))
        |-> (int'(llr_out[MW-1:0]) == lesser(int'($past(llr_a[MW-1:0])), int'($past(llr_b[MW-1:0])))));

      // R3
      g_add_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(sel_g) && !$past(psum))
        |-> (to_int(llr_out) == clip(to_int($past(llr_b)) + to_int($past(llr_a)))));

      // R4
      g_sub_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(sel_g) && $past(psum))
        |-> (to_int(llr_out) == clip(to_int($past(llr_b)) - to_int($past(llr_a)))));

      // R7
      no_negzero_chk: assert property (@(posedge clk) disable iff (rst)
        armed |-> (llr_out != {1'b1, {MW{1'b0}}}));

      // R8
      reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        rst_q |-> (llr_out == '0));
    end
  endgenerate
endmodule

bind sclr_pe sclr_pe_chk #(.LLR_W(LLR_W), .OUT_REG(OUT_REG)) u_sclr_pe_chk (
  .clk(clk), .rst(rst), .llr_a(llr_a), .llr_b(llr_b),
  .psum(psum), .sel_g(sel_g), .llr_out(llr_out)
);

// File: tb/sclr_pe_bench.sv
`timescale 1ns/1ps
module sclr_pe_bench;
  localparam int W    = 8;
  localparam int MAXM = 127;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] llr_a = '0, llr_b = '0;
  logic         psum = 1'b0, sel_g = 1'b0;
  logic [W-1:0] llr_out;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  sclr_pe u_sclr_pe (
    .clk(clk), .rst(rst), .llr_a(llr_a), .llr_b(llr_b),
    .psum(psum), .sel_g(sel_g), .llr_out(llr_out)
  );

  function automatic logic [W-1:0] sm(input int v);
    int m;
    m = (v < 0) ? -v : v;
    return {(v < 0), m[W-2:0]};
  endfunction

  function automatic int val(input logic [W-1:0] v);
    return v[W-1] ? -int'(v[W-2:0]) : int'(v[W-2:0]);
  endfunction

  // Reference model written from the requirements
  function automatic logic [W-1:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                         input logic g, input logic p);
    int r, ma, mb;
    if (!g) begin
      ma = int'(a[W-2:0]);
      mb = int'(b[W-2:0]);
      r  = (ma < mb) ? ma : mb;
      if (r != 0 && (a[W-1] ^ b[W-1])) r = -r;
    end else begin
      r = p ? val(b) - val(a) : val(b) + val(a);
      if (r > MAXM)  r = MAXM;
      if (r < -MAXM) r = -MAXM;
    end
    return sm(r);
  endfunction

  task automatic check(input string req, input logic [W-1:0] exp);
    n_chk++;
    if (llr_out !== exp) begin
      n_err++;
      $display("FAIL %s: a=%h b=%h g=%0b p=%0b actual=%h expected=%h",
               req, llr_a, llr_b, sel_g, psum, llr_out, exp);
    end
  endtask

  // Drive on a falling edge, sample one falling edge later
  task automatic run(input string req, input logic [W-1:0] a, input logic [W-1:0] b,
                     input logic g, input logic p);
    @(negedge clk);
    llr_a = a; llr_b = b; sel_g = g; psum = p;
    @(negedge clk);
    check(req, model(a, b, g, p));
  endtask

  task automatic t_reset;
    run("R8", sm(40), sm(-9), 1'b1, 1'b0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R8", '0);                       // R8 clear on reset
    rst = 1'b0;
  endtask

  task automatic t_check_rule;
    run("R1", sm(12), sm(-30), 1'b0, 1'b0);  // R1 R2 mixed signs
    run("R1", sm(-50), sm(-7), 1'b0, 1'b1);  // R1 both negative, psum ignored
    run("R2", sm(127), sm(126), 1'b0, 1'b0); // R2
    run("R2", sm(33), sm(33), 1'b0, 1'b0);   // R2 equal magnitudes
  endtask

  task automatic t_var_rule;
    run("R3", sm(20), sm(-5), 1'b1, 1'b0);   // R3 -> 15
    run("R3", sm(-60), sm(-60), 1'b1, 1'b0); // R3 -> -120
    run("R4", sm(20), sm(-5), 1'b1, 1'b1);   // R4 -> -25
    run("R4", sm(-70), sm(50), 1'b1, 1'b1);  // R4 -> 120
  endtask

  task automatic t_saturate;
    run("R5", sm(100), sm(100), 1'b1, 1'b0);   // R5 +127
    run("R5", sm(-127), sm(-127), 1'b1, 1'b0); // R5 -127
    run("R5", sm(127), sm(-127), 1'b1, 1'b1);  // R5 -127
    run("R5", sm(-64), sm(64), 1'b1, 1'b1);    // R5 128 -> +127
  endtask

  task automatic t_negzero;
    run("R6", 8'h80, sm(-44), 1'b1, 1'b0);   // R6 -> -44
    run("R6", 8'h80, sm(44), 1'b1, 1'b1);    // R6 -> 44
    run("R6", 8'h80, sm(-9), 1'b0, 1'b0);    // R6 f -> +0
    run("R6", 8'h80, 8'h80, 1'b1, 1'b0);     // R6 -> +0
  endtask

  task automatic t_zero_sign;
    run("R7", sm(-5), sm(-5), 1'b1, 1'b1);   // R7 -5-(-5) = +0
    run("R7", sm(9), sm(-9), 1'b1, 1'b0);    // R7 -9+9 = +0
    run("R7", sm(0), sm(-3), 1'b0, 1'b0);    // R7 min 0 -> +0
  endtask

  task automatic t_random;
    for (int i = 0; i < 300; i++) begin
      logic [W-1:0] a, b;
      a = W'($urandom);
      b = W'($urandom);
      if (i % 5 == 0) a[W-2:0] = {(W-1){1'b1}};
      if (i % 7 == 0) b[W-2:0] = '0;
      for (int k = 0; k < 4; k++) begin
        // k: 0,1 check rule; 2 -> R3; 3 -> R4
        run((k < 2) ? "R2" : (k == 2) ? "R3" : "R4", a, b, k[1], k[0]);
      end
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8", '0);                         // R8 reset state
    rst = 1'b0;
    t_reset;
    t_check_rule;
    t_var_rule;
    t_saturate;
    t_negzero;
    t_zero_sign;
    t_random;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule